// File: doc/BRIEF.md
# BCD Calendar Clock with Update Cycle

This block keeps a running calendar time (second, minute, hour, weekday, day of month, month and a two-digit year) and advances it by one second on each pulse of a 1 Hz enable. The running time is held in binary. Seven visible byte registers present it to the rest of the chip. Two mode inputs choose between BCD and plain binary encoding and between 24-hour and 12-hour form. In 12-hour form the hour byte carries a PM flag in its top bit. Software writes land in the visible registers and are decoded back into the running time.

Each accepted second starts an update window. The window is timed by a 32 kHz enable, and an update-in-progress flag is raised for its duration. When the window closes, a one-cycle update-done strobe fires for the neighbouring status and alarm logic, and the visible registers are refreshed from the running time. A three-bit oscillator control field gates counting. A set-mode input freezes the visible registers so that software can compose a new time. Leaving set mode loads that time into the counter.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, `time_regs` holds byte i at bits 8i+7:8i, with field order 0 second, 1 minute, 2 hour, 3 weekday, 4 day of month, 5 month, 6 year, and reads 00,00,00,01,01,01,00 for those fields. `update_busy` and `update_done` are 0.
- R2: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0.
- R3: A day rollover advances the weekday, which wraps from 7 to 1, and the day of month. The month wraps from 12 to 1 and carries into the year, which counts modulo 100 (99 wraps to 00).
- R4: Day-of-month limits are 31 for months 1,3,5,7,8,10,12 and 30 for months 4,6,9,11. February has 28 days, or 29 when BASE_YEAR+year is divisible by 4 and is not a century year, or is divisible by 400.
- R5: With `bin_mode`=0, each field is BCD with tens in bits 7:4 and units in bits 3:0. With `bin_mode`=1, each field is plain binary.
- R6: With `hr24_mode`=0, bit 7 of the hour byte is 1 for hours 12..23, and internal hours 0 and 12 both show as 12. A written hour of 12 decodes to 0 when bit 7 is 0 and to 12 when it is 1.
- R7: A `sec_tick` is accepted only when `osc_sel` equals RUN_CODE (default 3'b010). With any other value the time holds, `update_busy` stays 0, and nothing changes on the outputs.
- R8: An accepted tick advances the running time and raises `update_busy` at the following edge (unless set mode is on). The window closes after UIP_CYCLES `osc_tick` enables. `update_busy` then falls and `update_done` pulses for exactly one cycle. The visible registers are refreshed at the next edge. A `sec_tick` that arrives while a window is open is ignored.
- R9: While `set_mode`=1, `update_busy` is held at 0. Visible registers are neither refreshed by updates nor re-encoded by mode changes, and only direct writes alter them.
- R10: When `set_mode` falls, the visible registers are decoded with the current mode bits and loaded into the running time two edges later.
- R11: A write with `set_mode`=0 stores `wr_data` in field `wr_field` at the next edge and reloads the running time from the visible registers at the edge after. A `wr_field` of 7 selects no field.
- R12: A change of `bin_mode` or `hr24_mode` while `set_mode`=0 re-encodes all visible registers from the running time at the first edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle 1 Hz advance enable |
| osc_tick | input | 1 | 32 kHz enable timing the update window |
| osc_sel | input | 3 | Oscillator control; counting only at RUN_CODE |
| set_mode | input | 1 | Freeze visible registers for setting |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_field | input | 3 | Field index for the write |
| wr_data | input | 8 | Encoded field value to write |
| time_regs | output | 56 | Seven visible field bytes, field i at bits 8i+7:8i |
| update_busy | output | 1 | Update-in-progress flag |
| update_done | output | 1 | One-cycle strobe when an update window closes |

## Verification
The bench drives the time across the end of a year, across the ends of 30-day months, and across February in a plain year, a leap year and a leap century year. A wrong month table or leap rule shows up there as a day 29, 31 or 32 where the month should have turned. It re-encodes a live time between BCD, binary and 12-hour form, and crosses midnight and noon in 12-hour form. A design that mishandled hour 12 or the PM flag would read 00 or lose bit 7 in those cases. It checks that a tick arriving during an open update window is dropped and that the registers refresh only after `update_done`. It also checks that set mode keeps the registers frozen against updates and mode changes, and that on release the composed time is decoded with the modes in force at that moment. A design that decoded at write time or refreshed during set mode would show the wrong fields after the switch back to BCD.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int NUM_FIELDS = 7;
   localparam int FIELD_W    = 8;
   localparam int F_SEC      = 0;
   localparam int F_MIN      = 1;
   localparam int F_HOUR     = 2;
   localparam int F_WDAY     = 3;
   localparam int F_MDAY     = 4;
   localparam int F_MON      = 5;
   localparam int F_YEAR     = 6;

   // running time, always binary
   typedef struct packed {
      logic [6:0] year;   // 0..99 past the base year
      logic [3:0] mon;    // 1..12
      logic [4:0] mday;   // 1..31
      logic [2:0] wday;   // 1..7
      logic [4:0] hour;   // 0..23
      logic [5:0] min;    // 0..59
      logic [5:0] sec;    // 0..59
   } cal_time_t;

   function automatic logic [7:0] pack_field(input logic [6:0] v, input logic bin_sel);
      logic [6:0] tens;
      logic [6:0] units;
      tens  = v / 7'd10;
      units = v % 7'd10;
      return bin_sel ? {1'b0, v} : {tens[3:0], units[3:0]};
   endfunction

   function automatic logic [7:0] unpack_field(input logic [7:0] b, input logic bin_sel);
      logic [7:0] hi;
      logic [7:0] lo;
      hi = {4'd0, b[7:4]};
      lo = {4'd0, b[3:0]};
      return bin_sel ? b : (hi * 8'd10 + lo);
   endfunction

   function automatic logic leap_year(input logic [11:0] y);
      return ((y % 12'd4) == 12'd0) &&
             (((y % 12'd100) != 12'd0) || ((y % 12'd400) == 12'd0));
   endfunction

   function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                    return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/cal_time_counter.sv
module cal_time_counter
   import cal_pkg::*;
#(
   parameter int BASE_YEAR = 2000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  cal_time_t load_val,
   input  logic      advance,
   output cal_time_t cur
);

   localparam logic [11:0] BASE = 12'(BASE_YEAR);

   cal_time_t   nxt;
   logic [11:0] full_year;
   logic [4:0]  dim;
   logic [6:0]  sec_p;
   logic [6:0]  min_p;
   logic [5:0]  hour_p;
   logic [5:0]  mday_p;

   always_comb begin
      full_year = BASE + {5'd0, cur.year};
      dim       = month_days(cur.mon, leap_year(full_year));
      sec_p     = {1'b0, cur.sec} + 7'd1;
      min_p     = {1'b0, cur.min} + 7'd1;
      hour_p    = {1'b0, cur.hour} + 6'd1;
      mday_p    = {1'b0, cur.mday} + 6'd1;
      nxt       = cur;
      if (sec_p >= 7'd60) begin
         nxt.sec = '0;
         if (min_p >= 7'd60) begin
            nxt.min = '0;
            if (hour_p >= 6'd24) begin
               nxt.hour = '0;
               nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
               if (mday_p > {1'b0, dim}) begin
                  nxt.mday = 5'd1;
                  if (cur.mon >= 4'd12) begin
                     nxt.mon  = 4'd1;
                     nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                  end else begin
                     nxt.mon = cur.mon + 4'd1;
                  end
               end else begin
                  nxt.mday = mday_p[4:0];
               end
            end else begin
               nxt.hour = hour_p[4:0];
            end
         end else begin
            nxt.min = min_p[5:0];
         end
      end else begin
         nxt.sec = sec_p[5:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                  hour: 5'd0, min: 6'd0, sec: 6'd0};
      end else if (load) begin
         cur <= load_val;
      end else if (advance) begin
         cur <= nxt;
      end
   end

endmodule

// File: rtl/cal_update_seq.sv
module cal_update_seq #(
   parameter int UIP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic osc_tick,
   input  logic set_mode,
   output logic busy,
   output logic uip,
   output logic done
);

   localparam int            CW   = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

   logic [CW-1:0] cnt;
   logic          closing;

   assign closing = busy && osc_tick && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (closing) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else if (busy && osc_tick) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uip <= 1'b0;
      end else if (set_mode) begin
         uip <= 1'b0;
      end else if (start) begin
         uip <= 1'b1;
      end else if (closing) begin
         uip <= 1'b0;
      end
   end

endmodule

// File: rtl/cal_field_codec.sv
module cal_field_codec
   import cal_pkg::*;
(
   input  cal_time_t                           cur,
   input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  vis,
   input  logic                                bin_sel,
   input  logic                                hr24_sel,
   output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  enc,
   output cal_time_t                           dec
);

   logic [6:0] plain [NUM_FIELDS];

   always_comb begin
      plain[F_SEC]  = {1'b0, cur.sec};
      plain[F_MIN]  = {1'b0, cur.min};
      plain[F_HOUR] = {2'b0, cur.hour};
      plain[F_WDAY] = {4'b0, cur.wday};
      plain[F_MDAY] = {2'b0, cur.mday};
      plain[F_MON]  = {3'b0, cur.mon};
      plain[F_YEAR] = cur.year;
   end

   // encoder: the hour field gets the 12/24-hour variant, others plain
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_enc
      if (i == F_HOUR) begin : g_hour
         logic [6:0] h_mod;
         logic [6:0] h12;
         logic       pm;
         always_comb begin
            h_mod = plain[i] % 7'd12;
            h12   = (h_mod == 7'd0) ? 7'd12 : h_mod;
            pm    = plain[i] >= 7'd12;
         end
         assign enc[i] = hr24_sel ? pack_field(plain[i], bin_sel)
                                  : (pack_field(h12, bin_sel) | {pm, 7'd0});
      end else begin : g_plain
         assign enc[i] = pack_field(plain[i], bin_sel);
      end
   end

   // decoder: visible bytes back to binary running time
   logic [7:0] hr_raw;
   logic [7:0] hr_12;

   always_comb begin
      hr_raw   = unpack_field({1'b0, vis[F_HOUR][6:0]}, bin_sel);
      hr_12    = (hr_raw % 8'd12) + (vis[F_HOUR][7] ? 8'd12 : 8'd0);
      dec.sec  = 6'(unpack_field(vis[F_SEC], bin_sel));
      dec.min  = 6'(unpack_field(vis[F_MIN], bin_sel));
      dec.hour = hr24_sel ? 5'(hr_raw) : 5'(hr_12);
      dec.wday = 3'(unpack_field(vis[F_WDAY], bin_sel));
      dec.mday = 5'(unpack_field(vis[F_MDAY], bin_sel));
      dec.mon  = 4'(unpack_field(vis[F_MON], bin_sel));
      dec.year = 7'(unpack_field(vis[F_YEAR], bin_sel));
   end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import cal_pkg::*;
#(
   parameter int         BASE_YEAR  = 2000,
   parameter int         UIP_CYCLES = 8,
   parameter logic [2:0] RUN_CODE   = 3'b010
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sec_tick,
   input  logic                          osc_tick,
   input  logic [2:0]                    osc_sel,
   input  logic                          set_mode,
   input  logic                          bin_mode,
   input  logic                          hr24_mode,
   input  logic                          wr_en,
   input  logic [2:0]                    wr_field,
   input  logic [7:0]                    wr_data,
   output logic [NUM_FIELDS*FIELD_W-1:0] time_regs,
   output logic                          update_busy,
   output logic                          update_done
);

   localparam int SEL_W = $clog2(NUM_FIELDS);

   if (UIP_CYCLES < 1) begin : g_bad_window
      $error("UIP_CYCLES must be at least 1");
   end
   if (BASE_YEAR < 0 || BASE_YEAR > 3996) begin : g_bad_base
      $error("BASE_YEAR out of the supported range");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("field select width must be 3");
   end

   logic [NUM_FIELDS-1:0][FIELD_W-1:0] vis;
   logic [NUM_FIELDS-1:0][FIELD_W-1:0] enc;
   cal_time_t cur_time;
   cal_time_t dec_time;
   logic      seq_busy;
   logic      accept;
   logic      load_pend;
   logic      set_q;
   logic      bin_q;
   logic      hr24_q;
   logic      mode_chg;

   assign accept   = sec_tick && (osc_sel == RUN_CODE) && !seq_busy;
   assign mode_chg = (bin_mode != bin_q) || (hr24_mode != hr24_q);

   cal_time_counter #(.BASE_YEAR(BASE_YEAR)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_pend),
      .load_val (dec_time),
      .advance  (accept),
      .cur      (cur_time)
   );

   cal_update_seq #(.UIP_CYCLES(UIP_CYCLES)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .osc_tick (osc_tick),
      .set_mode (set_mode),
      .busy     (seq_busy),
      .uip      (update_busy),
      .done     (update_done)
   );

   cal_field_codec i_codec (
      .cur      (cur_time),
      .vis      (vis),
      .bin_sel  (bin_mode),
      .hr24_sel (hr24_mode),
      .enc      (enc),
      .dec      (dec_time)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_q     <= 1'b0;
         bin_q     <= 1'b0;
         hr24_q    <= 1'b1;
         load_pend <= 1'b0;
      end else begin
         set_q     <= set_mode;
         bin_q     <= bin_mode;
         hr24_q    <= hr24_mode;
         load_pend <= (wr_en && !set_mode) || (set_q && !set_mode);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) begin
            vis[i] <= ((i == F_WDAY) || (i == F_MDAY) || (i == F_MON)) ? 8'h01 : 8'h00;
         end
      end else begin
         for (int i = 0; i < NUM_FIELDS; i++) begin
            if (wr_en && (wr_field == SEL_W'(i))) begin
               vis[i] <= wr_data;
            end else if (!set_mode && (update_done || mode_chg)) begin
               vis[i] <= enc[i];
            end
         end
      end
   end

   assign time_regs = vis;

endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
   import cal_pkg::*;
#(
   parameter logic [2:0] RUN_CODE = 3'b010
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [2:0]                    osc_sel,
   input logic                          set_mode,
   input logic                          wr_en,
   input logic                          load_pend,
   input logic                          accept,
   input logic                          seq_busy,
   input logic                          update_busy,
   input logic                          update_done,
   input logic [NUM_FIELDS*FIELD_W-1:0] time_regs,
   input cal_time_t                     cur_time
);

   // R8: the done strobe marks the cycle the window closes
   p_done_ends_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      update_done |-> (!seq_busy && $past(seq_busy)));

   // R8: the in-progress flag is only up inside a window
   p_uip_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      update_busy |-> seq_busy);

   // R8: done lasts a single cycle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      update_done |=> !update_done);

   // R9: set mode keeps the in-progress flag low
   p_set_blocks_uip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode |=> !update_busy);

   // R9: in set mode only writes touch the visible registers
   p_set_freezes_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mode && !wr_en) |=> $stable(time_regs));

   // R7: a stopped oscillator holds the running time
   p_osc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((osc_sel != RUN_CODE) && !load_pend) |=> $stable(cur_time));

   // R2: an advance always leaves the seconds in range
   p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !load_pend) |=> (cur_time.sec < 6'd60));

endmodule

bind bcd_calendar_clock cal_clock_checker #(.RUN_CODE(RUN_CODE)) i_cal_clock_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .osc_sel     (osc_sel),
   .set_mode    (set_mode),
   .wr_en       (wr_en),
   .load_pend   (load_pend),
   .accept      (accept),
   .seq_busy    (seq_busy),
   .update_busy (update_busy),
   .update_done (update_done),
   .time_regs   (time_regs),
   .cur_time    (cur_time)
);

// File: tb/test_bcd_calendar_clock.sv
module test_bcd_calendar_clock;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        osc_tick = 1'b1;
   logic [2:0]  osc_sel = 3'b010;
   logic        set_mode = 1'b0;
   logic        bin_mode = 1'b0;
   logic        hr24_mode = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_field = 3'd0;
   logic [7:0]  wr_data = 8'd0;
   logic [55:0] time_regs;
   logic        update_busy;
   logic        update_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bcd_calendar_clock i_bcd_calendar_clock (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_tick    (sec_tick),
      .osc_tick    (osc_tick),
      .osc_sel     (osc_sel),
      .set_mode    (set_mode),
      .bin_mode    (bin_mode),
      .hr24_mode   (hr24_mode),
      .wr_en       (wr_en),
      .wr_field    (wr_field),
      .wr_data     (wr_data),
      .time_regs   (time_regs),
      .update_busy (update_busy),
      .update_done (update_done)
   );

   function automatic logic [7:0] fld(input int i);
      return time_regs[8*i +: 8];
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_time(input string tag, input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] wd, input logic [7:0] md,
                           input logic [7:0] mo, input logic [7:0] yr);
      chk(tag, {8'h00, time_regs}, {8'h00, yr, mo, md, wd, h, m, s});
   endtask

   task automatic tick_sec();
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
   endtask

   task automatic run_second();
      tick_sec();
      repeat (12) @(negedge clk);
   endtask

   task automatic wr(input int f, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_field = 3'(f);
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo,
                            input logic [7:0] yr);
      @(negedge clk) set_mode = 1'b1;
      wr(0, s); wr(1, m); wr(2, h); wr(3, wd); wr(4, md); wr(5, mo); wr(6, yr);
      @(negedge clk) set_mode = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 reset fields", {8'h00, time_regs}, 64'h0000010101000000);
      chk("R1 reset busy", {63'd0, update_busy}, 64'd0);
      chk("R1 reset done", {63'd0, update_done}, 64'd0);
   endtask

   task automatic t_basic();
      load_time(8'h56, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h23);
      run_second();
      chk_time("R2 R5 plain second", 8'h57, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h23);
      load_time(8'h59, 8'h59, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      run_second();
      chk_time("R2 minute and hour carry", 8'h00, 8'h00, 8'h11, 8'h03, 8'h15, 8'h06, 8'h23);
   endtask

   task automatic t_year_roll();
      load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      run_second();
      chk_time("R3 year end rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
   endtask

   task automatic t_months();
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
      run_second();
      chk_time("R4 Feb plain year", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23);
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
      run_second();
      chk_time("R4 Feb leap year", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24);
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
      run_second();
      chk_time("R4 Feb 29 end", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h24);
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
      run_second();
      chk_time("R4 Feb century by 400", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00);
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23);
      run_second();
      chk_time("R4 30-day month", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h23);
      load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h23);
      run_second();
      chk_time("R4 31-day month", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h02, 8'h23);
   endtask

   task automatic t_binary();
      @(negedge clk) bin_mode = 1'b1;
      repeat (2) @(negedge clk);
      load_time(8'h3B, 8'h3B, 8'h17, 8'h01, 8'h1C, 8'h02, 8'h17);
      run_second();
      chk_time("R5 binary rollover", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h17);
      @(negedge clk) bin_mode = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_mode_switch();
      load_time(8'h30, 8'h07, 8'h15, 8'h04, 8'h10, 8'h08, 8'h21);
      @(negedge clk) bin_mode = 1'b1;
      @(negedge clk);
      chk("R12 R5 binary hour", {56'd0, fld(2)}, 64'h0F);
      chk("R12 R5 binary second", {56'd0, fld(0)}, 64'h1E);
      @(negedge clk) hr24_mode = 1'b0;
      @(negedge clk);
      chk("R12 R6 binary 12h PM", {56'd0, fld(2)}, 64'h83);
      @(negedge clk) begin hr24_mode = 1'b1; bin_mode = 1'b0; end
      @(negedge clk);
      chk("R12 back to BCD 24h", {56'd0, fld(2)}, 64'h15);
   endtask

   task automatic t_twelve();
      @(negedge clk) hr24_mode = 1'b0;
      repeat (2) @(negedge clk);
      load_time(8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h05, 8'h20);
      run_second();
      chk_time("R6 midnight is 12 AM", 8'h00, 8'h00, 8'h12, 8'h02, 8'h11, 8'h05, 8'h20);
      load_time(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h05, 8'h20);
      run_second();
      chk_time("R6 noon is 12 PM", 8'h00, 8'h00, 8'h92, 8'h01, 8'h10, 8'h05, 8'h20);
      load_time(8'h00, 8'h00, 8'h12, 8'h01, 8'h10, 8'h05, 8'h20);
      @(negedge clk) hr24_mode = 1'b1;
      @(negedge clk);
      chk("R6 12 AM decodes to 0", {56'd0, fld(2)}, 64'h00);
   endtask

   task automatic t_osc_hold();
      load_time(8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      @(negedge clk) osc_sel = 3'b000;
      tick_sec();
      chk("R7 no busy when stopped", {63'd0, update_busy}, 64'd0);
      repeat (12) @(negedge clk);
      chk_time("R7 time held", 8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      @(negedge clk) osc_sel = 3'b011;
      run_second();
      chk("R7 other code holds", {56'd0, fld(0)}, 64'h30);
      @(negedge clk) osc_sel = 3'b010;
      run_second();
      chk("R7 runs at run code", {56'd0, fld(0)}, 64'h31);
   endtask

   task automatic t_window();
      load_time(8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      tick_sec();
      chk("R8 busy after tick", {63'd0, update_busy}, 64'd1);
      chk("R8 regs not yet refreshed", {56'd0, fld(0)}, 64'h30);
      repeat (2) @(negedge clk);
      tick_sec();
      repeat (3) @(negedge clk);
      chk("R8 busy near end", {63'd0, update_busy}, 64'd1);
      @(negedge clk);
      chk("R8 busy falls", {63'd0, update_busy}, 64'd0);
      chk("R8 done pulse", {63'd0, update_done}, 64'd1);
      chk("R8 refresh waits for done", {56'd0, fld(0)}, 64'h30);
      @(negedge clk);
      chk("R8 refreshed", {56'd0, fld(0)}, 64'h31);
      chk("R8 done one cycle", {63'd0, update_done}, 64'd0);
      repeat (6) @(negedge clk);
      chk("R8 tick in window dropped", {56'd0, fld(0)}, 64'h31);
   endtask

   task automatic t_set_mode();
      load_time(8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      @(negedge clk) set_mode = 1'b1;
      tick_sec();
      chk("R9 no busy in set mode", {63'd0, update_busy}, 64'd0);
      repeat (12) @(negedge clk);
      chk("R9 no refresh in set mode", {56'd0, fld(0)}, 64'h30);
      @(negedge clk) bin_mode = 1'b1;
      repeat (2) @(negedge clk);
      chk_time("R9 no re-encode in set mode", 8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      wr(0, 8'h2D);
      chk("R9 write lands in set mode", {56'd0, fld(0)}, 64'h2D);
      @(negedge clk) set_mode = 1'b0;
      repeat (3) @(negedge clk);
      run_second();
      chk_time("R10 binary decode on release", 8'h2E, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      @(negedge clk) bin_mode = 1'b0;
      @(negedge clk);
      chk_time("R10 R12 re-encoded BCD", 8'h46, 8'h32, 8'h16, 8'h03, 8'h21, 8'h06, 8'h35);
   endtask

   task automatic t_live_write();
      load_time(8'h30, 8'h20, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      wr(1, 8'h55);
      chk("R11 write visible", {56'd0, fld(1)}, 64'h55);
      wr(7, 8'hAA);
      chk_time("R11 field 7 selects nothing", 8'h30, 8'h55, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
      repeat (2) @(negedge clk);
      run_second();
      chk_time("R11 write reloads time", 8'h31, 8'h55, 8'h10, 8'h03, 8'h15, 8'h06, 8'h23);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_year_roll();
      t_months();
      t_binary();
      t_mode_switch();
      t_twelve();
      t_osc_hold();
      t_window();
      t_set_mode();
      t_live_write();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R8 got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule